// File: doc/BRIEF.md
# Local Interrupt Pin Delivery Controller

This block converts two level-sensitive interrupt pins into the events a processor core acts on. Each pin is brought into the clock domain and watched for rising edges. A global enable bit picks one of two modes. With the bit clear, the pins behave as a classic pair: pin 0 is a maskable request whose vector has to be fetched from an external interrupt controller, and pin 1 raises a non-maskable interrupt. With the bit set, each pin obeys its own vector table entry. That entry chooses a delivery mode (fixed vector, external acknowledge, NMI or none), holds an 8-bit vector and carries a mask bit.

The block also models the parts of the core that decide whether an event is taken: the interrupt-enable flag and a halted state. Maskable requests wait in a per-pin latch until the flag allows them. An NMI is always delivered. A halted core whose flag is clear can therefore be woken only by a pin that is set to NMI delivery. The vector table lookup after delivery, the bus protocol of the acknowledge cycle and any inter-processor messaging are outside this block.

Top module: `lpin_deliver`

## Requirements
- R1: A pin level passes through a two-flop synchroniser, and only a rising edge counts. If a pin goes high between two clock edges, the resulting delivery pulse appears on the fourth rising clock edge after that change.
- R2: With the global enable clear, a rising edge on pin 0 makes an external-acknowledge request and a rising edge on pin 1 makes a one-cycle NMI pulse on `nmi_o`.
- R3: An external-acknowledge delivery raises `ack_req_o` and holds it until `ack_valid_i` is sampled high. On that same clock edge `ack_req_o` drops and `vec_valid_o` pulses with `vec_o` equal to `ack_vec_i`. While no responder answers, the request stays open and no other maskable delivery starts.
- R4: In fixed mode, a delivery pulses `vec_valid_o` for one cycle, and `vec_o` carries the 8-bit vector held in that pin's entry. Every value from 0x00 to 0xFF is valid.
- R5: Fixed and external-acknowledge deliveries are maskable. While `if_o` is 0 they are held pending. Each pending request is delivered exactly once, after the flag is set.
- R6: `halt_i` sets `halted_o`. Any delivery (NMI pulse, vector pulse or start of an acknowledge) clears `halted_o` and pulses `wake_o` in the same cycle. A pending maskable request with the flag clear leaves the core halted.
- R7: An entry whose mask bit is set makes its pin ignored in every mode, including when the global enable is clear. An edge seen while the pin is masked is dropped and is not delivered after the pin is unmasked.
- R8: A pending NMI is delivered before any maskable request. Among maskable requests, pin 0 is served before pin 1.
- R9: A new NMI edge that arrives while an NMI is pending or its pulse is on `nmi_o` is merged into it, so only one pulse results. A second edge on a pin whose maskable request is still pending is also merged.
- R10: After reset the global enable is 0, `if_o` and `halted_o` are 0, all outputs are low, and every entry is unmasked and set to fixed mode with vector 0.
- R11: The write port maps address 0 to pin 0's entry, address 1 to pin 1's entry and address 2 to the global enable (bit 0). A write to address 3 has no effect. Entry layout: bits 7:0 vector, bits 9:8 mode (00 fixed, 01 external acknowledge, 10 NMI, 11 no delivery), bit 10 mask.
- R12: `if_set_i` sets the interrupt flag and `if_clr_i` clears it. When both are high, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 2 | Asynchronous interrupt pin levels |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration write address |
| cfg_wdata_i | input | 11 | Configuration write data |
| if_set_i | input | 1 | Set the interrupt-enable flag |
| if_clr_i | input | 1 | Clear the interrupt-enable flag |
| halt_i | input | 1 | Core enters the halted state |
| ack_valid_i | input | 1 | External responder answers the acknowledge |
| ack_vec_i | input | 8 | Vector returned by the responder |
| nmi_o | output | 1 | One-cycle NMI delivery pulse |
| vec_valid_o | output | 1 | One-cycle vectored delivery pulse |
| vec_o | output | 8 | Delivered vector, valid with `vec_valid_o` |
| ack_req_o | output | 1 | External acknowledge request outstanding |
| wake_o | output | 1 | One-cycle pulse when a halted core is woken |
| halted_o | output | 1 | Core is halted |
| if_o | output | 1 | Interrupt-enable flag |

## Verification
Some rules hold on every cycle, and properties check them there: each NMI is a single-cycle pulse, an edge pulse never repeats on the next cycle, a fixed-vector pulse only follows a set flag and never shares a cycle with an NMI, an acknowledge never starts while an NMI waits, every wake has a delivery beside it, and a write to the unmapped address leaves the mode unchanged. Other behaviour needs scenarios. The four-edge latency, pin-to-mode mapping, dropping masked edges instead of keeping them, the exactly-once release of a held request, merging of close NMI edges, and a halted core staying asleep with its flag clear can only be shown by driving the pins and following the reference model cycle by cycle.

// File: rtl/lpin_pkg.sv
// Shared types for the local interrupt pin delivery controller.
// Assumes a vector is 8 bits wide and an entry packs mask, mode and vector.
package lpin_pkg;
    parameter int VEC_W = 8;

    // Delivery mode field of a vector table entry
    typedef enum logic [1:0] {
        DLV_FIXED  = 2'b00,
        DLV_EXTACK = 2'b01,
        DLV_NMI    = 2'b10,
        DLV_NONE   = 2'b11
    } dlv_mode_e;

    // One vector table entry: bit 10 mask, bits 9:8 mode, bits 7:0 vector
    typedef struct packed {
        logic             masked;
        dlv_mode_e        mode;
        logic [VEC_W-1:0] vec;
    } lvt_entry_t;

    // Resolved request kind of a pin after mode and mask are applied
    typedef enum logic [1:0] {
        KIND_NONE  = 2'b00,
        KIND_FIXED = 2'b01,
        KIND_EXT   = 2'b10,
        KIND_NMI   = 2'b11
    } req_kind_e;
endpackage

// File: rtl/lpin_sync.sv
// Per-pin synchroniser and rising-edge detector.
// Assumes pins are asynchronous levels; STAGES >= 2 flops guard metastability,
// one extra flop holds the previous synchronised level.
module lpin_sync #(
    parameter int NUM_PINS = 2,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] rise_o
);
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic [STAGES:0] shreg_q;

        // Shift the raw pin level through the synchroniser chain
        always_ff @(posedge clk) begin
            if (!rst_n) shreg_q <= '0;
            else        shreg_q <= {shreg_q[STAGES-1:0], pin_i[g]};
        end

        assign rise_o[g] = shreg_q[STAGES-1] & ~shreg_q[STAGES];

        // An edge pulse lasts exactly one cycle
        assert_rise_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |=> !rise_o[g])
            else $error("edge pulse longer than one cycle");
    end
endmodule

// File: rtl/lpin_table.sv
// Vector table entries, global enable, and per-pin request classification.
// Assumes address NUM_PINS selects the global enable and higher addresses
// are unmapped; the legacy mapping covers pins 0 and 1 only.
module lpin_table
    import lpin_pkg::*;
#(
    parameter int NUM_PINS = 2,
    parameter int ADDR_W   = 2,
    parameter int ENTRY_W  = 11
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [ENTRY_W-1:0]              wdata_i,
    output req_kind_e [NUM_PINS-1:0]        kind_o,
    output logic [NUM_PINS-1:0][VEC_W-1:0]  vec_o,
    output logic                            glob_en_o
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_PINS);

    logic glob_en_q;

    // Global mode register, reset to legacy mode
    always_ff @(posedge clk) begin
        if (!rst_n)                              glob_en_q <= 1'b0;
        else if (we_i && addr_i == CTRL_ADDR)    glob_en_q <= wdata_i[0];
    end

    assign glob_en_o = glob_en_q;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        lvt_entry_t ent_q;
        req_kind_e  kind_g;

        // Entry register for this pin
        always_ff @(posedge clk) begin
            if (!rst_n)                                ent_q <= '0;
            else if (we_i && addr_i == ADDR_W'(g))     ent_q <= lvt_entry_t'(wdata_i);
        end

        // Map mode, mask and global enable to a request kind
        always_comb begin
            kind_g = KIND_NONE;
            if (!ent_q.masked) begin
                if (!glob_en_q) begin
                    if (g == 0)      kind_g = KIND_EXT;
                    else if (g == 1) kind_g = KIND_NMI;
                    else             kind_g = KIND_NONE;
                end else begin
                    unique case (ent_q.mode)
                        DLV_FIXED:  kind_g = KIND_FIXED;
                        DLV_EXTACK: kind_g = KIND_EXT;
                        DLV_NMI:    kind_g = KIND_NMI;
                        default:    kind_g = KIND_NONE;
                    endcase
                end
            end
        end

        assign kind_o[g] = kind_g;
        assign vec_o[g]  = ent_q.vec;
    end

    // Writes beyond the map leave the mode untouched
    assert_unmapped_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i > CTRL_ADDR) |=> $stable(glob_en_q))
        else $error("unmapped write changed global enable");
endmodule

// File: rtl/lpin_arbiter.sv
// Pending-request latches, delivery arbitration, interrupt flag and halt model.
// Assumes request kinds are already resolved; NMI outranks maskable requests,
// lower pin index outranks higher among maskable ones.
module lpin_arbiter
    import lpin_pkg::*;
#(
    parameter int NUM_PINS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PINS-1:0]            rise_i,
    input  req_kind_e [NUM_PINS-1:0]       kind_i,
    input  logic [NUM_PINS-1:0][VEC_W-1:0] vec_i,
    input  logic                           if_set_i,
    input  logic                           if_clr_i,
    input  logic                           halt_i,
    input  logic                           ack_valid_i,
    input  logic [VEC_W-1:0]               ack_vec_i,
    output logic                           nmi_o,
    output logic                           vec_valid_o,
    output logic [VEC_W-1:0]               vec_o,
    output logic                           ack_req_o,
    output logic                           wake_o,
    output logic                           halted_o,
    output logic                           if_o
);
    localparam int SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic                nmi_pend_q, nmi_q, busy_q, vv_q, wake_q, halted_q, if_q;
    logic [VEC_W-1:0]    vec_q;
    logic [NUM_PINS-1:0] mpend_q, mext_q;
    logic [VEC_W-1:0]    mvec_q [NUM_PINS];

    logic             nmi_edge, any_pend, grant, ack_start, ack_done, fix_fire, deliver;
    logic [SEL_W-1:0] sel;

    // Any pin in NMI kind showing a rising edge
    always_comb begin
        nmi_edge = 1'b0;
        for (int i = 0; i < NUM_PINS; i++)
            if (rise_i[i] && kind_i[i] == KIND_NMI) nmi_edge = 1'b1;
    end

    // Lowest-index pending maskable request
    always_comb begin
        sel      = '0;
        any_pend = 1'b0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (mpend_q[i]) begin
                sel      = SEL_W'(i);
                any_pend = 1'b1;
            end
        end
    end

    assign grant     = any_pend && !nmi_pend_q && if_q && !busy_q;
    assign ack_start = grant && mext_q[sel];
    assign fix_fire  = grant && !mext_q[sel];
    assign ack_done  = busy_q && ack_valid_i;
    assign deliver   = nmi_pend_q || fix_fire || ack_done || ack_start;

    // NMI pending flag and pulse, with merging of close edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_pend_q <= 1'b0;
            nmi_q      <= 1'b0;
        end else begin
            nmi_q      <= nmi_pend_q;
            nmi_pend_q <= nmi_edge && !nmi_pend_q && !nmi_q;
        end
    end

    // Per-pin maskable request latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mpend_q <= '0;
            mext_q  <= '0;
            for (int i = 0; i < NUM_PINS; i++) mvec_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_PINS; i++) begin
                if (grant && sel == SEL_W'(i)) mpend_q[i] <= 1'b0;
                if (rise_i[i] && !mpend_q[i] &&
                    (kind_i[i] == KIND_FIXED || kind_i[i] == KIND_EXT)) begin
                    mpend_q[i] <= 1'b1;
                    mext_q[i]  <= (kind_i[i] == KIND_EXT);
                    mvec_q[i]  <= vec_i[i];
                end
            end
        end
    end

    // External acknowledge handshake state
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (ack_done)  busy_q <= 1'b0;
        else if (ack_start) busy_q <= 1'b1;
    end

    // Vector delivery pulse and value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vv_q  <= 1'b0;
            vec_q <= '0;
        end else begin
            vv_q <= ack_done || fix_fire;
            if (ack_done)      vec_q <= ack_vec_i;
            else if (fix_fire) vec_q <= mvec_q[sel];
        end
    end

    // Halted state and wake pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted_q <= 1'b0;
            wake_q   <= 1'b0;
        end else begin
            wake_q   <= halted_q && deliver;
            halted_q <= deliver ? 1'b0 : (halted_q || halt_i);
        end
    end

    // Interrupt-enable flag, clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n)        if_q <= 1'b0;
        else if (if_clr_i) if_q <= 1'b0;
        else if (if_set_i) if_q <= 1'b1;
    end

    assign nmi_o       = nmi_q;
    assign vec_valid_o = vv_q;
    assign vec_o       = vec_q;
    assign ack_req_o   = busy_q;
    assign wake_o      = wake_q;
    assign halted_o    = halted_q;
    assign if_o        = if_q;

    assert_nmi_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |=> !nmi_o)
        else $error("NMI pulse not merged");

    assert_wake_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (nmi_o || vec_valid_o || $rose(ack_req_o)))
        else $error("wake without delivery");

    assert_fixed_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && !$past(busy_q)) |-> $past(if_q))
        else $error("maskable delivered with flag clear");

    assert_fixed_not_with_nmi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && !$past(busy_q)) |-> !nmi_o)
        else $error("fixed vector beside NMI pulse");

    assert_ack_after_nmi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req_o) |-> (!$past(nmi_pend_q) && $past(if_q)))
        else $error("acknowledge started ahead of NMI or with flag clear");
endmodule

// File: rtl/lpin_deliver.sv
// Top of the local interrupt pin delivery controller.
// Assumes pins are asynchronous levels and the core model is driven
// synchronously; composes synchroniser, table and arbiter.
module lpin_deliver
    import lpin_pkg::*;
#(
    parameter  int NUM_PINS    = 2,
    parameter  int SYNC_STAGES = 2,
    localparam int ADDR_W      = $clog2(NUM_PINS + 1),
    localparam int ENTRY_W     = $bits(lvt_entry_t)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                cfg_we_i,
    input  logic [ADDR_W-1:0]   cfg_addr_i,
    input  logic [ENTRY_W-1:0]  cfg_wdata_i,
    input  logic                if_set_i,
    input  logic                if_clr_i,
    input  logic                halt_i,
    input  logic                ack_valid_i,
    input  logic [VEC_W-1:0]    ack_vec_i,
    output logic                nmi_o,
    output logic                vec_valid_o,
    output logic [VEC_W-1:0]    vec_o,
    output logic                ack_req_o,
    output logic                wake_o,
    output logic                halted_o,
    output logic                if_o
);
    logic [NUM_PINS-1:0]            rise;
    req_kind_e [NUM_PINS-1:0]       kind;
    logic [NUM_PINS-1:0][VEC_W-1:0] ent_vec;
    logic                           glob_en;

    lpin_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .rise_o (rise)
    );

    lpin_table #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we_i),
        .addr_i    (cfg_addr_i),
        .wdata_i   (cfg_wdata_i),
        .kind_o    (kind),
        .vec_o     (ent_vec),
        .glob_en_o (glob_en)
    );

    lpin_arbiter #(.NUM_PINS(NUM_PINS)) i_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .kind_i      (kind),
        .vec_i       (ent_vec),
        .if_set_i    (if_set_i),
        .if_clr_i    (if_clr_i),
        .halt_i      (halt_i),
        .ack_valid_i (ack_valid_i),
        .ack_vec_i   (ack_vec_i),
        .nmi_o       (nmi_o),
        .vec_valid_o (vec_valid_o),
        .vec_o       (vec_o),
        .ack_req_o   (ack_req_o),
        .wake_o      (wake_o),
        .halted_o    (halted_o),
        .if_o        (if_o)
    );

    // Legacy mode (enable clear) holds right after reset
    assert_legacy_after_reset_R10: assert property (@(posedge clk)
        !rst_n |=> !glob_en)
        else $error("global enable not cleared by reset");
endmodule

// File: tb/test_lpin_deliver.sv
`timescale 1ns/1ps
module test_lpin_deliver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pin = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [10:0] cfg_wdata = '0;
    logic        if_set = 1'b0, if_clr = 1'b0, halt = 1'b0;
    logic        ack_valid = 1'b0;
    logic [7:0]  ack_vec = '0;
    logic        nmi_o, vec_valid_o, ack_req_o, wake_o, halted_o, if_o;
    logic [7:0]  vec_o;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int nmi_cnt = 0, vv_cnt = 0, wake_cnt = 0, nmi_cyc = 0, vec_cyc = 0;
    int last_vec = 0, prev_vec = 0;

    always #2.5 clk = ~clk;

    lpin_deliver i_lpin_deliver (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
        .cfg_wdata_i(cfg_wdata), .if_set_i(if_set), .if_clr_i(if_clr), .halt_i(halt),
        .ack_valid_i(ack_valid), .ack_vec_i(ack_vec), .nmi_o(nmi_o), .vec_valid_o(vec_valid_o),
        .vec_o(vec_o), .ack_req_o(ack_req_o), .wake_o(wake_o), .halted_o(halted_o), .if_o(if_o)
    );

    // ---------------- reference model ----------------
    bit          p1 [2], p2 [2], p3 [2];
    bit          m_en, m_npend, m_busy, m_if, m_halt;
    bit          m_pend [2], m_ext [2];
    logic [7:0]  m_pvec [2];
    logic [10:0] m_ent [2];
    bit          e_nmi, e_vv, e_ack, e_wake;
    logic [7:0]  e_vec;

    always @(posedge clk) begin
        bit e [2];
        int kind [2];
        bit pend_old [2];
        bit nmi_edge, grant, start, done, fire, dl;
        int sel;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                p1[i] = 0; p2[i] = 0; p3[i] = 0; m_pend[i] = 0; m_ext[i] = 0;
                m_pvec[i] = 0; m_ent[i] = 0;
            end
            m_en = 0; m_npend = 0; m_busy = 0; m_if = 0; m_halt = 0;
            e_nmi = 0; e_vv = 0; e_ack = 0; e_wake = 0; e_vec = 0;
        end else begin
            // kinds: 0 none, 1 fixed, 2 ext, 3 nmi
            for (int i = 0; i < 2; i++) begin
                e[i] = p2[i] && !p3[i];
                if (m_ent[i][10]) kind[i] = 0;
                else if (!m_en) kind[i] = (i == 0) ? 2 : 3;
                else case (m_ent[i][9:8])
                    2'b00: kind[i] = 1;
                    2'b01: kind[i] = 2;
                    2'b10: kind[i] = 3;
                    default: kind[i] = 0;
                endcase
                pend_old[i] = m_pend[i];
            end
            nmi_edge = (e[0] && kind[0] == 3) || (e[1] && kind[1] == 3);
            sel = -1;
            for (int i = 1; i >= 0; i--) if (m_pend[i]) sel = i;
            grant = (sel >= 0) && !m_npend && m_if && !m_busy;
            start = grant && m_ext[sel];
            fire  = grant && !m_ext[sel];
            done  = m_busy && ack_valid;
            if (done) e_vec = ack_vec;
            else if (fire) e_vec = m_pvec[sel];
            e_vv = done || fire;
            dl = m_npend || e_vv || start;
            e_wake = m_halt && dl;
            m_halt = dl ? 0 : (m_halt || halt);
            begin
                bit nxt;
                nxt = nmi_edge && !m_npend && !e_nmi;
                e_nmi = m_npend;
                m_npend = nxt;
            end
            if (done) m_busy = 0; else if (start) m_busy = 1;
            e_ack = m_busy;
            if (grant) m_pend[sel] = 0;
            for (int i = 0; i < 2; i++)
                if (e[i] && (kind[i] == 1 || kind[i] == 2) && !pend_old[i]) begin
                    m_pend[i] = 1; m_ext[i] = (kind[i] == 2); m_pvec[i] = m_ent[i][7:0];
                end
            if (if_clr) m_if = 0; else if (if_set) m_if = 1;
            if (cfg_we) begin
                if (cfg_addr == 2'd0) m_ent[0] = cfg_wdata;
                else if (cfg_addr == 2'd1) m_ent[1] = cfg_wdata;
                else if (cfg_addr == 2'd2) m_en = cfg_wdata[0];
            end
            for (int i = 0; i < 2; i++) begin p3[i] = p2[i]; p2[i] = p1[i]; p1[i] = pin[i]; end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison and event monitor, sampled 1 ns after the edge
    always @(posedge clk) begin
        #1;
        cyc++;
        chk("R2 nmi_o", int'(nmi_o), int'(e_nmi));
        chk("R4 vec_valid_o", int'(vec_valid_o), int'(e_vv));
        if (e_vv) chk("R4 vec_o", int'(vec_o), int'(e_vec));
        chk("R3 ack_req_o", int'(ack_req_o), int'(e_ack));
        chk("R6 wake_o", int'(wake_o), int'(e_wake));
        chk("R6 halted_o", int'(halted_o), int'(m_halt));
        chk("R12 if_o", int'(if_o), int'(m_if));
        if (nmi_o === 1'b1) begin nmi_cnt++; nmi_cyc = cyc; end
        if (wake_o === 1'b1) wake_cnt++;
        if (vec_valid_o === 1'b1) begin
            vv_cnt++; vec_cyc = cyc; prev_vec = last_vec; last_vec = int'(vec_o);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, logic [10:0] d);
        cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = d; tick(1); cfg_we = 0;
    endtask

    task automatic pulse_pin(logic [1:0] p);
        pin = p; tick(1); pin = '0;
    endtask

    task automatic pulse_if(bit s, bit c);
        if_set = s; if_clr = c; tick(1); if_set = 0; if_clr = 0;
    endtask

    task automatic do_halt();
        halt = 1; tick(1); halt = 0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        int c0;
        tick(3);
        rst_n = 1;
        tick(1);
        // R10 reset state
        chk("R10 nmi_o", int'(nmi_o), 0);
        chk("R10 vec_valid_o", int'(vec_valid_o), 0);
        chk("R10 ack_req_o", int'(ack_req_o), 0);
        chk("R10 halted_o/if_o", int'({halted_o, if_o}), 0);

        // R2 legacy NMI wakes a halted core with flag clear; R1 latency
        do_halt();
        c0 = cyc;
        pulse_pin(2'b10);
        tick(6);
        chk("R2 legacy NMI count", nmi_cnt, 1);
        chk("R1 latency", nmi_cyc, c0 + 4);
        chk("R6 NMI wake count", wake_cnt, 1);
        chk("R6 woken", int'(halted_o), 0);

        // R12 flag control
        pulse_if(1, 0); tick(1);
        chk("R12 set", int'(if_o), 1);
        pulse_if(1, 1); tick(1);
        chk("R12 clear wins", int'(if_o), 0);
        pulse_if(1, 0); tick(1);

        // R3 legacy pin 0 external acknowledge, no responder then responder
        pulse_pin(2'b01);
        tick(16);
        chk("R3 request held", int'(ack_req_o), 1);
        chk("R3 no completion", vv_cnt, 0);
        ack_valid = 1; ack_vec = 8'h5A; tick(1); ack_valid = 0;
        tick(2);
        chk("R3 vector from responder", last_vec, 8'h5A);
        chk("R3 request dropped", int'(ack_req_o), 0);

        // R4/R8/R11 configured fixed vectors on both pins
        wr(0, {1'b0, 2'b00, 8'h34});
        wr(1, {1'b0, 2'b00, 8'h33});
        wr(2, 11'h001);
        pulse_pin(2'b11);
        tick(6);
        chk("R4 two deliveries", vv_cnt, 3);
        chk("R8 pin0 first", prev_vec, 8'h34);
        chk("R4 pin1 vector", last_vec, 8'h33);

        // R5/R6 maskable held while flag clear, core stays halted
        pulse_if(0, 1);
        do_halt();
        pulse_pin(2'b01);
        tick(10);
        chk("R5 held", vv_cnt, 3);
        chk("R6 still halted", int'(halted_o), 1);
        pulse_if(1, 0);
        tick(3);
        chk("R5 released", vv_cnt, 4);
        chk("R5 released vector", last_vec, 8'h34);
        chk("R6 maskable wake", wake_cnt, 2);
        tick(5);
        chk("R5 delivered once", vv_cnt, 4);

        // R6 pin in NMI mode wakes halted core with flag clear
        wr(1, {1'b0, 2'b10, 8'h00});
        pulse_if(0, 1);
        do_halt();
        pulse_pin(2'b10);
        tick(6);
        chk("R6 NMI mode count", nmi_cnt, 2);
        chk("R6 NMI mode wake", wake_cnt, 3);

        // R8 NMI before fixed in the same cycle
        pulse_if(1, 0);
        pulse_pin(2'b11);
        tick(6);
        chk("R8 NMI delivered", nmi_cnt, 3);
        chk("R8 order", vec_cyc, nmi_cyc + 1);

        // R9 NMI edges one cycle apart merge
        wr(0, {1'b0, 2'b10, 8'h00});
        pin = 2'b10; tick(1); pin = 2'b01; tick(1); pin = 2'b00;
        tick(6);
        chk("R9 merged NMI", nmi_cnt, 4);

        // R7 masked edge dropped, configured and legacy
        wr(0, {1'b1, 2'b00, 8'h77});
        pulse_pin(2'b01);
        tick(6);
        wr(0, {1'b0, 2'b00, 8'h77});
        tick(6);
        chk("R7 masked fixed dropped", vv_cnt, 5);
        wr(2, 11'h000);
        wr(1, {1'b1, 2'b00, 8'h00});
        pulse_pin(2'b10);
        tick(6);
        chk("R7 masked legacy NMI", nmi_cnt, 4);

        // R11 unmapped write and no-delivery mode
        wr(1, {1'b0, 2'b00, 8'h00});
        wr(3, 11'h7FF);
        pulse_pin(2'b10);
        tick(6);
        chk("R11 still legacy", nmi_cnt, 5);
        chk("R11 no vector", vv_cnt, 5);
        wr(2, 11'h001);
        wr(1, {1'b0, 2'b11, 8'h12});
        pulse_pin(2'b10);
        tick(6);
        chk("R11 mode none", nmi_cnt + vv_cnt, 10);

        // R4 top vector value
        wr(0, {1'b0, 2'b00, 8'hFF});
        pulse_pin(2'b01);
        tick(6);
        chk("R4 vector 0xFF", last_vec, 8'hFF);
        chk("R4 count", vv_cnt, 6);

        finish_run();
    end
endmodule